// File: doc/BRIEF.md
# Min/Max Sample Pair Packer

This block takes a stream of converter samples, one per conversion clock, and splits it into two interleaved lanes. A free-running half-rate phase, set up at reset, loads a MIN holding register and a MAX holding register on alternate clocks. Once both halves of a pair are held, the block packs them into one double-width word and raises a one-clock write strobe. The strobe also serves as the advance pulse for a downstream memory address counter.

A static mode input chooses which phase feeds which register. An active-low test input replaces the converter byte with a built-in diagnostic counter. In test mode each MAX value is one more than the MIN value that came just before it, and the counter moves on by two for every pair. A memory filled this way can therefore be checked word by word. The acquire-enable input gates only the strobe. The packed word is updated for every pair either way.

Top module: `pair_pack_top`

## Requirements
- R1: While `rst_n` is low, `pack_word` is zero and `pack_wr` is low. Reset also returns the phase to even, the diagnostic counter to its seed (0) and the pair tracking to empty.
- R2: With `phase_sel` low, the first clock edge after reset (even phase) loads MIN. The edge after it (odd phase) loads MAX, and the two kinds of edge keep alternating from then on.
- R3: With `phase_sel` high, odd edges load MIN and even edges load MAX. A MAX load that no MIN load has preceded since reset (the first edge after reset) forms no word and raises no strobe.
- R4: The word holds MIN in bits 7:0 and MAX in bits 15:8. It appears on `pack_word` one clock after the edge that loaded MAX.
- R5: On the clock edge where a new word is loaded, `pack_wr` is high for exactly that one cycle, and only if `acq_en` is high at that edge. `pack_word` is updated for every completed pair, whatever `acq_en` is.
- R6: While `test_n` is low, a MIN load takes the diagnostic value n and a MAX load takes n+1, instead of `adc_data`.
- R7: The diagnostic value n starts at 0 after reset. It rises by 2, modulo 256, at each MAX load that completes a pair while `test_n` is low.
- R8: While `test_n` is low, `adc_data` has no effect on `pack_word`.
- R9: `pack_wr` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_data | input | 8 | Converter sample, one per clock |
| phase_sel | input | 1 | 0: MIN on even phase, MAX on odd; 1: swapped. Change only under reset |
| test_n | input | 1 | Active-low diagnostic mode select |
| acq_en | input | 1 | Enables the write strobe |
| pack_word | output | 16 | Packed pair, MAX in high byte, MIN in low byte |
| pack_wr | output | 1 | One-clock write strobe for `pack_word` |

## Verification
The bench targets the swapped phase mode straight after reset. A design that paired the orphan first MAX with the reset MIN value would emit a spurious word, and every later word would pair the wrong samples. It runs test mode long enough for the diagnostic counter to wrap past 255, which catches a counter that stalls, steps by one, or advances on unpaired loads. It also holds `acq_en` low over completed pairs to catch a design that suppresses the word together with the strobe or that lets a strobe through anyway. Random switching of `test_n` in the middle of a pair checks that the source multiplexer acts per sample and not per pair.

// File: rtl/pp_pkg.sv
package pp_pkg;
   typedef enum logic {PH_EVEN = 1'b0, PH_ODD = 1'b1} phase_e;

   function automatic phase_e next_phase(phase_e p);
      return (p == PH_EVEN) ? PH_ODD : PH_EVEN;
   endfunction
endpackage

// File: rtl/pp_phase.sv
module pp_phase
   import pp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic phase_sel,
   output logic min_load,
   output logic max_load
);
   phase_e ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_EVEN;
      else        ph_q <= next_phase(ph_q);
   end

   // phase_sel low: MIN on even phase; high: MIN on odd phase
   always_comb begin
      min_load = ((ph_q == PH_EVEN) != phase_sel);
      max_load = !min_load;
   end
endmodule

// File: rtl/pp_diag.sv
module pp_diag #(
   parameter int SAMPLE_W = 8,
   parameter int SEED     = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                advance,
   output logic [SAMPLE_W-1:0] lo_val,
   output logic [SAMPLE_W-1:0] hi_val
);
   localparam logic [SAMPLE_W-1:0] SEED_V = SAMPLE_W'(SEED);
   localparam logic [SAMPLE_W-1:0] STEP   = SAMPLE_W'(2);
   localparam logic [SAMPLE_W-1:0] ONE    = SAMPLE_W'(1);

   logic [SAMPLE_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= SEED_V;
      else if (advance) cnt_q <= cnt_q + STEP;
   end

   always_comb begin
      lo_val = cnt_q;
      hi_val = cnt_q + ONE;
   end
endmodule

// File: rtl/pp_pair.sv
module pp_pair #(
   parameter int SAMPLE_W    = 8,
   parameter bit MAX_IN_HIGH = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  min_load,
   input  logic                  max_load,
   input  logic [SAMPLE_W-1:0]   sample,
   input  logic                  acq_en,
   output logic                  pair_done,
   output logic [2*SAMPLE_W-1:0] word,
   output logic                  wr
);
   localparam int WORD_W = 2 * SAMPLE_W;

   logic [SAMPLE_W-1:0] min_q, max_q;
   logic                min_seen_q, rdy_q;
   logic [WORD_W-1:0]   packed_w, word_q;
   logic                wr_q;

   assign pair_done = max_load & min_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         min_q      <= '0;
         max_q      <= '0;
         min_seen_q <= 1'b0;
         rdy_q      <= 1'b0;
      end else begin
         rdy_q <= pair_done;
         if (min_load) begin
            min_q      <= sample;
            min_seen_q <= 1'b1;
         end
         if (max_load) max_q <= sample;
      end
   end

   generate
      if (MAX_IN_HIGH) begin : g_max_high
         assign packed_w = {max_q, min_q};
      end else begin : g_min_high
         assign packed_w = {min_q, max_q};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         wr_q   <= 1'b0;
      end else begin
         wr_q <= rdy_q & acq_en;
         if (rdy_q) word_q <= packed_w;
      end
   end

   assign word = word_q;
   assign wr   = wr_q;
endmodule

// File: rtl/pair_pack_top.sv
module pair_pack_top #(
   parameter int SAMPLE_W    = 8,
   parameter int DIAG_SEED   = 0,
   parameter bit MAX_IN_HIGH = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [SAMPLE_W-1:0]   adc_data,
   input  logic                  phase_sel,
   input  logic                  test_n,
   input  logic                  acq_en,
   output logic [2*SAMPLE_W-1:0] pack_word,
   output logic                  pack_wr
);
   generate
      if (SAMPLE_W < 2) begin : g_bad_width
         $error("pair_pack_top: SAMPLE_W must be at least 2");
      end
      if (DIAG_SEED < 0 || DIAG_SEED >= (1 << SAMPLE_W)) begin : g_bad_seed
         $error("pair_pack_top: DIAG_SEED out of range");
      end
   endgenerate

   logic                min_load, max_load, pair_done;
   logic [SAMPLE_W-1:0] diag_lo, diag_hi, diag_sel, sample;

   pp_phase u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_sel(phase_sel),
      .min_load (min_load),
      .max_load (max_load)
   );

   pp_diag #(.SAMPLE_W(SAMPLE_W), .SEED(DIAG_SEED)) u_diag (
      .clk    (clk),
      .rst_n  (rst_n),
      .advance(pair_done & ~test_n),
      .lo_val (diag_lo),
      .hi_val (diag_hi)
   );

   always_comb begin
      diag_sel = min_load ? diag_lo : diag_hi;
      sample   = test_n ? adc_data : diag_sel;
   end

   pp_pair #(.SAMPLE_W(SAMPLE_W), .MAX_IN_HIGH(MAX_IN_HIGH)) u_pair (
      .clk      (clk),
      .rst_n    (rst_n),
      .min_load (min_load),
      .max_load (max_load),
      .sample   (sample),
      .acq_en   (acq_en),
      .pair_done(pair_done),
      .word     (pack_word),
      .wr       (pack_wr)
   );
endmodule

// File: rtl/pair_pack_chk.sv
module pair_pack_chk #(
   parameter int SAMPLE_W = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  test_n,
   input logic                  acq_en,
   input logic [2*SAMPLE_W-1:0] pack_word,
   input logic                  pack_wr
);
   localparam logic [SAMPLE_W-1:0] ONE = SAMPLE_W'(1);
   localparam logic [SAMPLE_W-1:0] TWO = SAMPLE_W'(2);

   // R1: outputs cleared while reset held
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (pack_word == '0 && !pack_wr));

   // R9: strobe never on two consecutive cycles
   a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      pack_wr |=> !pack_wr);

   // R5: strobe only when acquire-enable sampled high at the loading edge
   a_r5_wr_needs_acq: assert property (@(posedge clk) disable iff (!rst_n)
      pack_wr |-> $past(acq_en));

   // R6: pair sampled fully in test mode has MAX = MIN + 1
   a_r6_test_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_wr && !$past(test_n, 2) && !$past(test_n, 3))
      |-> (pack_word[2*SAMPLE_W-1:SAMPLE_W] == pack_word[SAMPLE_W-1:0] + ONE));

   // R7: consecutive test-mode words step by two
   a_r7_step_two: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_wr && $past(pack_wr, 2) && !$past(test_n, 2) && !$past(test_n, 3)
       && !$past(test_n, 4) && !$past(test_n, 5))
      |-> (pack_word[SAMPLE_W-1:0] == $past(pack_word[SAMPLE_W-1:0], 2) + TWO));
endmodule

bind pair_pack_top pair_pack_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .test_n   (test_n),
   .acq_en   (acq_en),
   .pack_word(pack_word),
   .pack_wr  (pack_wr)
);

// File: tb/sim_pair_pack_top.sv
`timescale 1ns/1ps
module sim_pair_pack_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  adc_data = '0;
   logic        phase_sel = 1'b0;
   logic        test_n = 1'b1;
   logic        acq_en = 1'b0;
   logic [15:0] pack_word;
   logic        pack_wr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // bench model state
   bit       m_ph, m_min_seen, m_rdy, m_wr, m_prev_wr, m_pair_test, m_min_test;
   bit [7:0] m_min, m_max, m_n;
   bit [15:0] m_word;

   always #5 clk = ~clk;

   pair_pack_top u0 (
      .clk(clk), .rst_n(rst_n), .adc_data(adc_data), .phase_sel(phase_sel),
      .test_n(test_n), .acq_en(acq_en), .pack_word(pack_word), .pack_wr(pack_wr)
   );

   task automatic chk(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_ph = 0; m_min_seen = 0; m_rdy = 0; m_wr = 0; m_prev_wr = 0;
      m_min = 0; m_max = 0; m_n = 0; m_word = 0; m_pair_test = 0; m_min_test = 0;
   endtask

   task automatic do_reset(bit sel);
      @(negedge clk);
      rst_n = 0; phase_sel = sel;
      repeat (3) @(negedge clk);
      model_reset();
      chk(pack_word == 16'h0, "R1 word", pack_word, 0);
      chk(pack_wr == 1'b0, "R1 strobe", pack_wr, 0);
      rst_n = 1;
   endtask

   // inputs already driven (at negedge); advance model by one edge, then check
   task automatic step();
      bit is_min;
      bit [7:0] src;
      bit [15:0] nw;
      bit nwr;
      is_min = (m_ph == phase_sel);
      src = (!test_n) ? (is_min ? m_n : m_n + 8'd1) : adc_data;
      nwr = m_rdy & acq_en;
      nw = m_rdy ? {m_max, m_min} : m_word;
      if (m_rdy) m_pair_test = m_pair_test; // tag flag settled at MAX edge
      m_rdy = 0;
      if (is_min) begin
         m_min = src; m_min_seen = 1; m_min_test = !test_n;
      end else begin
         m_max = src;
         m_rdy = m_min_seen;
         if (m_min_seen) m_pair_test = m_min_test && !test_n;
         if (m_min_seen && !test_n) m_n = m_n + 8'd2;
      end
      m_ph = !m_ph;
      m_prev_wr = m_wr;
      m_word = nw; m_wr = nwr;
      @(negedge clk);
      chk(pack_wr == m_wr, "R5 strobe", pack_wr, m_wr);
      if (m_pair_test)
         chk(pack_word == m_word, "R6 R7 R8 test word", pack_word, m_word);
      else if (phase_sel)
         chk(pack_word == m_word, "R3 R4 swapped word", pack_word, m_word);
      else
         chk(pack_word == m_word, "R2 R4 word", pack_word, m_word);
      if (m_prev_wr) chk(!pack_wr, "R9 back-to-back", pack_wr, 0);
   endtask

   task automatic run(int cycles, int test_pct, int acq_pct);
      for (int i = 0; i < cycles; i++) begin
         adc_data = 8'($urandom);
         test_n   = !(($urandom % 100) < test_pct);
         acq_en   = (($urandom % 100) < acq_pct);
         step();
      end
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      model_reset();
      do_reset(1'b0);
      // R2 directed: first pair after reset, MIN=11 MAX=22
      test_n = 1; acq_en = 1;
      adc_data = 8'h11; step();
      adc_data = 8'h22; step();
      adc_data = 8'h33; step();
      chk(pack_word == 16'h2211 && pack_wr, "R2 R4 first pair", pack_word, 16'h2211);
      run(300, 0, 85);
      // R6 R7 R8: long test run, wraps the counter
      do_reset(1'b0);
      run(400, 100, 100);
      // R5: acquire disabled, words still move, no strobe
      run(60, 100, 0);
      // R3: swapped phase, orphan first MAX
      do_reset(1'b1);
      test_n = 1; acq_en = 1;
      adc_data = 8'hAA; step();
      chk(!pack_wr, "R3 orphan max", pack_wr, 0);
      adc_data = 8'h01; step();
      adc_data = 8'h02; step();
      chk(!pack_wr && pack_word == 16'h0, "R3 no word yet", pack_word, 0);
      adc_data = 8'h03; step();
      chk(pack_wr && pack_word == 16'h0201, "R3 R4 first swapped", pack_word, 16'h0201);
      run(300, 50, 80);
      // swapped test mode
      do_reset(1'b1);
      run(300, 100, 90);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule